// File: doc/BRIEF.md
# Paged Address Translation Map

This block sits between a network controller and a board's buffer memory. It maps the controller's 24-bit addresses onto physical buffer locations through a writable page map. The four most significant address bits play no part in the mapping. The next ten bits choose one of 1024 map slots. The ten low bits are the byte offset inside a 1 KiB page and reach the physical address unchanged. The map has no valid or protection bits: every lookup returns whatever the chosen slot holds.

Each 16-bit map entry holds three things. The first is a 12-bit physical frame number. The second is a select bit that tells the memory system whether the page is in on-board memory or on a secondary backplane bus. The third is a per-page byte-order flag. Pages held in little-endian order have their 16-bit lanes exchanged. The highest slot backs the top of the controller's space, where the controller fetches its boot pointer at 0xfffff4.

The host fills and inspects the map through a simple index/data register port. The same map serves both the host and the controller side. A lookup is registered and its result appears one clock cycle after the request.

Top module: `pmap_xlate`

## Requirements
- R1: After reset every map entry reads 0. A lookup then returns frame 0, on-board memory (`remote_o`=0) and `swap_o`=1. While in reset, `valid_o`, `paddr_o`, `remote_o` and `swap_o` are all 0.
- R2: A lookup presented with `req_valid_i`=1 shows its result in the following cycle. In that cycle `valid_o`=1 and `paddr_o` = {entry[11:0], req_addr_i[9:0]}.
- R3: Address bits 23..20 have no effect. Addresses that differ only in those bits return identical outputs.
- R4: The map slot index is req_addr_i[19:10]. Neighbouring slots give independent translations, including across a page boundary.
- R5: `swap_o` is the inverse of entry bit 15. Bit 15 = 1 means big-endian (host) order and no swap. Bit 15 = 0 means little-endian order, with swap.
- R6: `remote_o` equals entry bit 13. A value of 1 selects backplane memory and 0 selects on-board memory.
- R7: Entry bits 14 and 12 do not change any lookup output. A lookup always completes with `valid_o`=1, whatever the entry holds.
- R8: A host write (`host_we_i`=1) updates the slot at the clock edge. A lookup to the same slot in the same cycle returns the old entry. A lookup in any later cycle returns the new entry.
- R9: `host_rdata_o` shows, one cycle later, all 16 bits of the slot selected by `host_idx_i`. This includes bits 14 and 12.
- R10: Slot 1023 translates the boot-pointer address 0xfffff4. The result is paddr = {entry1023[11:0], 10'h3f4}.
- R11: In a cycle after `req_valid_i`=0, `valid_o` is 0, and `paddr_o`, `remote_o` and `swap_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Controller lookup request |
| req_addr_i | input | 24 | Controller address |
| host_we_i | input | 1 | Host map write strobe |
| host_idx_i | input | 10 | Host map slot index |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Registered host read data |
| valid_o | output | 1 | Lookup result valid |
| paddr_o | output | 22 | Physical buffer address |
| remote_o | output | 1 | 1 = backplane memory, 0 = on-board memory |
| swap_o | output | 1 | Exchange 16-bit byte lanes |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:
- Addresses that differ only in the top nibble must translate identically. A design that folded those bits into the index would return a different slot.
- A lookup that meets a write to the same slot must return the old entry, and the next cycle's lookup the new one. A design with write-through forwarding or a stale read would fail one of these two cycles.
- Entries with the reserved bits set must leave the outputs unchanged, while the host read-back still shows those bits.
- The byte-order bit must have the correct polarity. A design with it inverted would swap exactly the wrong pages.
- The boot-pointer lookup at 0xfffff4 must land in slot 1023 with offset 0x3f4.
- A page-boundary pair of addresses must reach two different slots.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int ENTRY_W = 16;
  localparam int FRAME_W = 12;

  // entry layout is host-visible: order bit 15, location bit 13, frame 11..0
  typedef struct packed {
    logic               host_order;
    logic               rsvd_hi;
    logic               remote;
    logic               rsvd_lo;
    logic [FRAME_W-1:0] frame;
  } pmap_entry_t;
endpackage

// File: rtl/pmap_addr_split.sv
module pmap_addr_split #(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam int USED_W = IDX_W + OFF_W;

  assign off_o = addr_i[OFF_W-1:0];
  assign idx_o = addr_i[OFF_W +: IDX_W];

  generate
    if (ADDR_W > USED_W) begin : g_drop
      logic unused_hi;
      assign unused_hi = ^addr_i[ADDR_W-1:USED_W];
    end
  endgenerate
endmodule

// File: rtl/pmap_table.sv
module pmap_table
  import pmap_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  pmap_entry_t       wdata_i,
  input  logic [IDX_W-1:0]  xl_idx_i,
  output pmap_entry_t       xl_entry_o,
  input  logic [IDX_W-1:0]  host_idx_i,
  output pmap_entry_t       host_entry_o
);
  localparam int DEPTH = 1 << IDX_W;

  pmap_entry_t map_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) map_q[i] <= '0;
    end else if (we_i) begin
      map_q[widx_i] <= wdata_i;
    end
  end

  assign xl_entry_o   = map_q[xl_idx_i];
  assign host_entry_o = map_q[host_idx_i];
endmodule

// File: rtl/pmap_out_stage.sv
module pmap_out_stage
  import pmap_pkg::*;
#(
  parameter int OFF_W = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [OFF_W-1:0]         off_i,
  input  pmap_entry_t              entry_i,
  input  pmap_entry_t              host_entry_i,
  output logic                     valid_o,
  output logic [FRAME_W+OFF_W-1:0] paddr_o,
  output logic                     remote_o,
  output logic                     swap_o,
  output logic [ENTRY_W-1:0]       host_rdata_o
);
  logic valid_q, remote_q, swap_q;
  logic [FRAME_W+OFF_W-1:0] paddr_q;
  logic [ENTRY_W-1:0] host_q;
  logic unused_rsvd;

  assign unused_rsvd = entry_i.rsvd_hi ^ entry_i.rsvd_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      paddr_q  <= '0;
      remote_q <= 1'b0;
      swap_q   <= 1'b0;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) begin
        paddr_q  <= {entry_i.frame, off_i};
        remote_q <= entry_i.remote;
        swap_q   <= ~entry_i.host_order; // little-endian page: exchange lanes
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_q <= '0;
    else         host_q <= host_entry_i;
  end

  assign valid_o      = valid_q;
  assign paddr_o      = paddr_q;
  assign remote_o     = remote_q;
  assign swap_o       = swap_q;
  assign host_rdata_o = host_q;
endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate
  import pmap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 10,
  localparam int PADDR_W = FRAME_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               host_we_i,
  input  logic [IDX_W-1:0]   host_idx_i,
  input  logic [ENTRY_W-1:0] host_wdata_i,
  output logic [ENTRY_W-1:0] host_rdata_o,
  output logic               valid_o,
  output logic [PADDR_W-1:0] paddr_o,
  output logic               remote_o,
  output logic               swap_o
);
  logic [IDX_W-1:0] xl_idx;
  logic [OFF_W-1:0] xl_off;
  pmap_entry_t      xl_entry, host_entry;

  pmap_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .addr_i (req_addr_i),
    .idx_o  (xl_idx),
    .off_o  (xl_off)
  );

  pmap_table #(.IDX_W(IDX_W)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (host_we_i),
    .widx_i       (host_idx_i),
    .wdata_i      (pmap_entry_t'(host_wdata_i)),
    .xl_idx_i     (xl_idx),
    .xl_entry_o   (xl_entry),
    .host_idx_i   (host_idx_i),
    .host_entry_o (host_entry)
  );

  pmap_out_stage #(.OFF_W(OFF_W)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .off_i        (xl_off),
    .entry_i      (xl_entry),
    .host_entry_i (host_entry),
    .valid_o      (valid_o),
    .paddr_o      (paddr_o),
    .remote_o     (remote_o),
    .swap_o       (swap_o),
    .host_rdata_o (host_rdata_o)
  );
endmodule

// File: rtl/pmap_xlate_chk.sv
module pmap_xlate_chk #(
  parameter int ADDR_W  = 24,
  parameter int IDX_W   = 10,
  parameter int OFF_W   = 10,
  parameter int ENTRY_W = 16,
  parameter int PADDR_W = 22
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic               host_we_i,
  input logic [IDX_W-1:0]   host_idx_i,
  input logic [ENTRY_W-1:0] host_wdata_i,
  input logic [ENTRY_W-1:0] host_rdata_o,
  input logic               valid_o,
  input logic [PADDR_W-1:0] paddr_o,
  input logic               remote_o,
  input logic               swap_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1: outputs cleared during reset
  always_comb begin
    if (!rst_ni) a_r1_reset_clear: assert (!valid_o && paddr_o == '0 && !remote_o && !swap_o);
  end

  a_r2_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni || age_q == 2'd0)
    valid_o == $past(req_valid_i));

  a_r2_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni || age_q == 2'd0)
    valid_o |-> paddr_o[OFF_W-1:0] == $past(req_addr_i[OFF_W-1:0]));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || age_q == 2'd0)
    !$past(req_valid_i) |-> ($stable(paddr_o) && $stable(remote_o) && $stable(swap_o)));

  // R5/R6: lookup and host port reading the same slot in one cycle agree
  a_r5_swap_matches_map: assert property (@(posedge clk_i) disable iff (!rst_ni || age_q == 2'd0)
    ($past(req_valid_i) && $past(req_addr_i[OFF_W +: IDX_W]) == $past(host_idx_i))
    |-> (swap_o == ~host_rdata_o[15]));

  a_r6_remote_matches_map: assert property (@(posedge clk_i) disable iff (!rst_ni || age_q == 2'd0)
    ($past(req_valid_i) && $past(req_addr_i[OFF_W +: IDX_W]) == $past(host_idx_i))
    |-> (remote_o == host_rdata_o[13] && paddr_o[PADDR_W-1:OFF_W] == host_rdata_o[11:0]));

  a_r8_write_then_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni || age_q < 2'd2)
    ($past(host_we_i, 2) && $past(req_valid_i)
     && $past(req_addr_i[OFF_W +: IDX_W]) == $past(host_idx_i, 2)
     && !($past(host_we_i) && $past(host_idx_i) == $past(req_addr_i[OFF_W +: IDX_W])))
    |-> (swap_o == ~$past(host_wdata_i[15], 2) && remote_o == $past(host_wdata_i[13], 2)));
endmodule

bind pmap_xlate pmap_xlate_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
  .ENTRY_W(pmap_pkg::ENTRY_W), .PADDR_W(PADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
  .host_we_i(host_we_i), .host_idx_i(host_idx_i), .host_wdata_i(host_wdata_i),
  .host_rdata_o(host_rdata_o), .valid_o(valid_o), .paddr_o(paddr_o),
  .remote_o(remote_o), .swap_o(swap_o)
);

// File: tb/sim_pmap_xlate.sv
`timescale 1ns/1ps
module sim_pmap_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic        host_we_i = 1'b0;
  logic [9:0]  host_idx_i = '0;
  logic [15:0] host_wdata_i = '0;
  logic [15:0] host_rdata_o;
  logic        valid_o;
  logic [21:0] paddr_o;
  logic        remote_o;
  logic        swap_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_map [1024];

  always #2.5 clk_i = ~clk_i;

  pmap_xlate u0 (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .host_we_i, .host_idx_i,
    .host_wdata_i, .host_rdata_o, .valid_o, .paddr_o, .remote_o, .swap_o
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] idx, input logic [15:0] data);
    @(negedge clk_i);
    host_we_i = 1'b1; host_idx_i = idx; host_wdata_i = data;
    @(negedge clk_i);
    host_we_i = 1'b0;
    exp_map[idx] = data;
  endtask

  task automatic do_lookup(input logic [23:0] addr);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = addr;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  // compare outputs against an entry value for an address
  task automatic expect_xl(input logic [23:0] addr, input logic [15:0] ent, input string tag);
    logic [21:0] ep;
    ep = {ent[11:0], addr[9:0]};
    check(valid_o === 1'b1, {tag, " valid"}, {31'b0, valid_o}, 32'd1);
    check(paddr_o === ep, {tag, " paddr"}, {10'b0, paddr_o}, {10'b0, ep});
    check(remote_o === ent[13], {tag, " remote"}, {31'b0, remote_o}, {31'b0, ent[13]});
    check(swap_o === ~ent[15], {tag, " swap"}, {31'b0, swap_o}, {31'b0, ~ent[15]});
  endtask

  task automatic t_reset;
    check(valid_o === 1'b0 && paddr_o === '0 && !remote_o && !swap_o, "R1 reset outputs",
          {9'b0, valid_o, paddr_o}, 32'd0);
    @(negedge clk_i); host_idx_i = 10'h3a5;
    @(negedge clk_i);
    check(host_rdata_o === 16'h0, "R1 reset map entry", {16'b0, host_rdata_o}, 32'd0);
    do_lookup(24'h123456);
    expect_xl(24'h123456, 16'h0000, "R1 lookup after reset");
  endtask

  task automatic t_basic;
    do_write(10'h155, 16'h8abc);
    do_lookup({4'h0, 10'h155, 10'h2a7});
    expect_xl({4'h0, 10'h155, 10'h2a7}, 16'h8abc, "R2 basic");
  endtask

  task automatic t_top_nibble;
    logic [21:0] ref_p;
    do_lookup({4'hf, 10'h155, 10'h011});
    expect_xl({4'hf, 10'h155, 10'h011}, 16'h8abc, "R3 top nibble F");
    ref_p = paddr_o;
    do_lookup({4'h7, 10'h155, 10'h011});
    check(paddr_o === ref_p, "R3 top nibble 7 vs F", {10'b0, paddr_o}, {10'b0, ref_p});
  endtask

  task automatic t_boundary;
    do_write(10'h156, 16'h2123);
    do_lookup(24'h0557ff);
    expect_xl(24'h0557ff, 16'h8abc, "R4 last byte slot 155");
    do_lookup(24'h055800);
    expect_xl(24'h055800, 16'h2123, "R4 first byte slot 156");
  endtask

  task automatic t_flags;
    logic [15:0] pats [4] = '{16'h0001, 16'h8002, 16'h2003, 16'ha004};
    for (int i = 0; i < 4; i++) begin
      do_write(10'h200 + 10'(i), pats[i]);
      do_lookup({4'h3, 10'h200 + 10'(i), 10'h100});
      expect_xl({4'h3, 10'h200 + 10'(i), 10'h100}, pats[i], "R5 R6 flag pattern");
    end
  endtask

  task automatic t_reserved;
    do_write(10'h0aa, 16'h5fff);
    do_lookup({4'h0, 10'h0aa, 10'h3ff});
    expect_xl({4'h0, 10'h0aa, 10'h3ff}, 16'h0fff, "R7 reserved bits ignored");
  endtask

  task automatic t_same_cycle;
    @(negedge clk_i);
    host_we_i = 1'b1; host_idx_i = 10'h155; host_wdata_i = 16'h2777;
    req_valid_i = 1'b1; req_addr_i = {4'h0, 10'h155, 10'h005};
    @(negedge clk_i);
    host_we_i = 1'b0; req_valid_i = 1'b0;
    expect_xl({4'h0, 10'h155, 10'h005}, 16'h8abc, "R8 same cycle old entry");
    exp_map[10'h155] = 16'h2777;
    do_lookup({4'h0, 10'h155, 10'h005});
    expect_xl({4'h0, 10'h155, 10'h005}, 16'h2777, "R8 next cycle new entry");
  endtask

  task automatic t_readback;
    do_write(10'h001, 16'h7fff);
    @(negedge clk_i); host_idx_i = 10'h001;
    @(negedge clk_i);
    check(host_rdata_o === 16'h7fff, "R9 readback full entry", {16'b0, host_rdata_o}, 32'h7fff);
    @(negedge clk_i); host_idx_i = 10'h0aa;
    @(negedge clk_i);
    check(host_rdata_o === exp_map[10'h0aa], "R9 readback reserved", {16'b0, host_rdata_o},
          {16'b0, exp_map[10'h0aa]});
  endtask

  task automatic t_boot;
    do_write(10'h3ff, 16'h20ff);
    do_lookup(24'hfffff4);
    expect_xl(24'hfffff4, 16'h20ff, "R10 boot pointer");
    check(paddr_o === {12'h0ff, 10'h3f4}, "R10 boot paddr", {10'b0, paddr_o}, {10'b0, 12'h0ff, 10'h3f4});
  endtask

  task automatic t_hold;
    logic [21:0] p;
    logic r, s;
    do_lookup(24'hfffff4);
    p = paddr_o; r = remote_o; s = swap_o;
    @(negedge clk_i); req_addr_i = 24'h000000;
    @(negedge clk_i);
    check(valid_o === 1'b0, "R11 valid low", {31'b0, valid_o}, 32'd0);
    check(paddr_o === p && remote_o === r && swap_o === s, "R11 outputs hold",
          {10'b0, paddr_o}, {10'b0, p});
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) exp_map[i] = '0;
    repeat (3) @(negedge clk_i);
    t_reset_pre: begin end
    check(valid_o === 1'b0, "R1 valid in reset", {31'b0, valid_o}, 32'd0);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_top_nibble();
    t_boundary();
    t_flags();
    t_reserved();
    t_same_cycle();
    t_readback();
    t_boot();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule